// File: doc/BRIEF.md
# Frequent Pattern Word Compressor

This block shrinks one cache line before it is stored in a cache that allocates data in 8-byte segments. A one-cycle `start` strobe captures a 512-bit line of sixteen 32-bit words. The block then walks the words, one per clock, starting with the least significant word. Each word is matched against a small set of common value shapes: small signed numbers, halfword-aligned values, paired small halfwords and byte replicas. A matching word is replaced by a 3-bit code and only the bits needed to rebuild it. Consecutive zero words collapse into a single run entry.

When the last word has been consumed, the block pulses `done`. At that point it presents the packed bitstream, its exact length in bits, and the number of 64-bit segments the result occupies. If the result is larger than eight segments, the line is flagged as not worth compressing and reported at eight segments. Every entry is self-describing through its leading code, so a downstream expander can peel entries off one at a time.

Top module: `fpc_line_compressor`

## Requirements
- R1: After reset, `busy`, `done`, `bitLen`, `segCount` and `incompressible` are all zero, and `bitStream` is all zero.
- R2: When `start` is high while the block is idle, the line is captured and `busy` is high from the next cycle. `done` is high for exactly one cycle, after the 16th rising edge that follows the accepting edge.
- R3: Entries are packed from bit 0 upward, in word order from word 0 (`lineIn[31:0]`). Each entry holds its 3-bit code in its lowest bits, with the data field directly above. The codes are: 000 zero run, 001 4-bit signed, 010 8-bit signed, 011 16-bit signed, 100 low halfword zero, 101 two byte-signed halfwords, 110 byte replica, 111 raw word.
- R4: The data field of each code is as follows:
  - 001: `w[3:0]`
  - 010: `w[7:0]`
  - 011: `w[15:0]`
  - 100: `w[31:16]`
  - 101: `{w[23:16], w[7:0]}`
  - 110: `w[7:0]`
  - 111: all 32 bits.
- R5: When several codes fit a word, the one with the fewest data bits is used. Among equal sizes, the numerically lowest code wins; for example, 0xFFFF0000 encodes as 100 and 0xFFFFFFFF encodes as 001.
- R6: A run of consecutive zero words becomes one 6-bit entry: code 000 with a 3-bit field above it holding (run length − 1). A run is closed after 8 words, and the zero words that follow start a new run. A run that reaches word 15 is closed there.
- R7: `bitLen` equals the sum of all entry widths (code plus data), and every `bitStream` bit at or above `bitLen` is zero.
- R8: `segCount` is `bitLen` divided by 64, rounded up. If that exceeds 8, `segCount` is 8 and `incompressible` is 1; otherwise `incompressible` is 0. A length of exactly 512 bits is 8 segments and compressible.
- R9: A `start` pulse while `busy` is high is ignored: the running line completes with its own result and its timing is unchanged.
- R10: Once `done` has pulsed, `bitStream`, `bitLen`, `segCount` and `incompressible` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture `lineIn` and begin compression when idle |
| lineIn | input | 512 | Line to compress, word 0 in bits 31:0 |
| busy | output | 1 | Words are being consumed |
| done | output | 1 | One-cycle pulse: results are valid |
| bitStream | output | 560 | Packed entries, first entry at bit 0 |
| bitLen | output | 10 | Total compressed length in bits |
| segCount | output | 4 | 64-bit segments needed, 1 to 8 |
| incompressible | output | 1 | Result exceeded eight segments |

## Verification
The checker assumes that `start` is a clean single-cycle pulse sampled on the rising edge. It also assumes the line is held only for the accepting edge, since the block keeps its own copy. The bench raises `start` for exactly one cycle at a falling edge and changes `lineIn` only when the block is idle, except in one scenario: there, a second pulse carrying a different line is sent mid-run on purpose. The rounding and cap properties on `segCount` rely on the length never exceeding 560 bits, which the fixed 16-word line guarantees.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int WORD_W   = 32;
  localparam int PREFIX_W = 3;
  localparam int RUN_W    = 3;
  localparam int RUN_MAX  = 1 << RUN_W;
  localparam int ENTRY_W  = PREFIX_W + WORD_W;
  localparam int RUN_ENTRY_W = PREFIX_W + RUN_W;
  localparam int SEG_BITS = 64;
  localparam int MAX_SEGS = 8;

  typedef enum logic [PREFIX_W-1:0] {
    PFX_ZRUN  = 3'b000,
    PFX_SE4   = 3'b001,
    PFX_SE8   = 3'b010,
    PFX_SE16  = 3'b011,
    PFX_HPAD  = 3'b100,
    PFX_HPAIR = 3'b101,
    PFX_RBYTE = 3'b110,
    PFX_RAW   = 3'b111
  } prefix_e;

  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } ctrl_strobe_t;
endpackage

// File: rtl/fpc_word_encoder.sv
module fpc_word_encoder import fpc_pkg::*; (
  input  logic [WORD_W-1:0]  word,
  output logic               isZero,
  output logic [ENTRY_W-1:0] entry,
  output logic [5:0]         entryLen
);
  logic fitSe4, fitSe8, fitSe16, fitPad, fitPair, fitRep;
  prefix_e pfx;
  logic [WORD_W-1:0] dataBits;
  logic [5:0] dataLen;

  always_comb begin
    isZero  = (word == '0);
    fitSe4  = (word[31:3]  == {29{word[3]}});
    fitSe8  = (word[31:7]  == {25{word[7]}});
    fitSe16 = (word[31:15] == {17{word[15]}});
    fitPad  = (word[15:0] == 16'h0000);
    fitPair = (word[31:23] == {9{word[23]}}) && (word[15:7] == {9{word[7]}});
    fitRep  = (word == {4{word[7:0]}});

    // ordered by data width, then by code value
    if (fitSe4) begin
      pfx = PFX_SE4;   dataBits = {28'd0, word[3:0]};             dataLen = 6'd4;
    end else if (fitSe8) begin
      pfx = PFX_SE8;   dataBits = {24'd0, word[7:0]};             dataLen = 6'd8;
    end else if (fitRep) begin
      pfx = PFX_RBYTE; dataBits = {24'd0, word[7:0]};             dataLen = 6'd8;
    end else if (fitSe16) begin
      pfx = PFX_SE16;  dataBits = {16'd0, word[15:0]};            dataLen = 6'd16;
    end else if (fitPad) begin
      pfx = PFX_HPAD;  dataBits = {16'd0, word[31:16]};           dataLen = 6'd16;
    end else if (fitPair) begin
      pfx = PFX_HPAIR; dataBits = {16'd0, word[23:16], word[7:0]}; dataLen = 6'd16;
    end else begin
      pfx = PFX_RAW;   dataBits = word;                           dataLen = 6'd32;
    end
    entry    = {dataBits, pfx};
    entryLen = dataLen + 6'(PREFIX_W);
  end
endmodule

// File: rtl/fpc_control.sv
module fpc_control import fpc_pkg::*; #(
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrl_strobe_t strb,
  output logic         busy,
  output logic         done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;
  state_e state;
  logic [IDX_W-1:0] idx;

  always_comb begin
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_RUN);
    strb.last = (state == ST_RUN) && (idx == IDX_W'(WORDS-1));
    busy      = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strb.last;
      if (strb.load) begin
        state <= ST_RUN;
        idx   <= '0;
      end else if (strb.last) begin
        state <= ST_IDLE;
      end else if (strb.step) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpc_datapath.sv
module fpc_datapath import fpc_pkg::*; #(
  parameter int WORDS = 16,
  localparam int LINE_W   = WORDS * WORD_W,
  localparam int MAX_BITS = WORDS * ENTRY_W,
  localparam int LEN_W    = $clog2(MAX_BITS + 1),
  localparam int SEG_W    = $clog2(MAX_SEGS + 1),
  localparam int COMB_W   = ENTRY_W + RUN_ENTRY_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strb,
  input  logic [LINE_W-1:0]   lineIn,
  output logic [MAX_BITS-1:0] bitStream,
  output logic [LEN_W-1:0]    bitLen,
  output logic [SEG_W-1:0]    segCount,
  output logic                incompressible
);
  logic [LINE_W-1:0] lineReg;
  logic [RUN_W:0]    runCnt;

  logic               isZero;
  logic [ENTRY_W-1:0] wordEntry;
  logic [5:0]         wordLen;

  fpc_word_encoder u_enc (
    .word     (lineReg[WORD_W-1:0]),
    .isZero   (isZero),
    .entry    (wordEntry),
    .entryLen (wordLen)
  );

  logic                   runClose, runEmit, wordEmit;
  logic [RUN_W:0]         runLen;
  logic [RUN_ENTRY_W-1:0] runEntry;
  logic [5:0]             runWidth, wordWidth;
  logic [6:0]             addWidth;
  logic [COMB_W-1:0]      combined;
  logic [MAX_BITS-1:0]    shifted;
  logic [LEN_W-1:0]       nextLen;
  logic [LEN_W:0]         segRaw;

  always_comb begin
    runClose  = isZero && ((runCnt == (RUN_W+1)'(RUN_MAX-1)) || strb.last);
    runEmit   = isZero ? runClose : (runCnt != '0);
    runLen    = isZero ? runCnt + 1'b1 : runCnt;
    runEntry  = {RUN_W'(runLen - 1'b1), PFX_ZRUN};
    wordEmit  = !isZero;
    runWidth  = runEmit  ? 6'(RUN_ENTRY_W) : 6'd0;
    wordWidth = wordEmit ? wordLen : 6'd0;
    addWidth  = {1'b0, runWidth} + {1'b0, wordWidth};
    combined  = (runEmit  ? COMB_W'(runEntry) : '0)
              | (wordEmit ? (COMB_W'(wordEntry) << runWidth) : '0);
    shifted   = MAX_BITS'(combined) << bitLen;
    nextLen   = bitLen + LEN_W'(addWidth);
    segRaw    = ({1'b0, nextLen} + (LEN_W+1)'(SEG_BITS-1)) / (LEN_W+1)'(SEG_BITS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg        <= '0;
      runCnt         <= '0;
      bitStream      <= '0;
      bitLen         <= '0;
      segCount       <= '0;
      incompressible <= 1'b0;
    end else if (strb.load) begin
      lineReg        <= lineIn;
      runCnt         <= '0;
      bitStream      <= '0;
      bitLen         <= '0;
      segCount       <= '0;
      incompressible <= 1'b0;
    end else if (strb.step) begin
      lineReg   <= lineReg >> WORD_W;
      bitStream <= bitStream | shifted;
      bitLen    <= nextLen;
      runCnt    <= (isZero && !runClose) ? runCnt + 1'b1 : '0;
      if (strb.last) begin
        if (segRaw > (LEN_W+1)'(MAX_SEGS)) begin
          segCount       <= SEG_W'(MAX_SEGS);
          incompressible <= 1'b1;
        end else begin
          segCount       <= SEG_W'(segRaw);
          incompressible <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fpc_line_compressor.sv
module fpc_line_compressor import fpc_pkg::*; #(
  parameter int WORDS = 16,
  localparam int LINE_W   = WORDS * WORD_W,
  localparam int MAX_BITS = WORDS * ENTRY_W,
  localparam int LEN_W    = $clog2(MAX_BITS + 1),
  localparam int SEG_W    = $clog2(MAX_SEGS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [LINE_W-1:0]   lineIn,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] bitStream,
  output logic [LEN_W-1:0]    bitLen,
  output logic [SEG_W-1:0]    segCount,
  output logic                incompressible
);
  ctrl_strobe_t strb;

  fpc_control #(.WORDS(WORDS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  fpc_datapath #(.WORDS(WORDS)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .lineIn         (lineIn),
    .bitStream      (bitStream),
    .bitLen         (bitLen),
    .segCount       (segCount),
    .incompressible (incompressible)
  );
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int LEN_W = 10,
  parameter int SEG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] bitLen,
  input logic [SEG_W-1:0] segCount,
  input logic             incompressible
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_seg_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (segCount >= SEG_W'(1)) && (segCount <= SEG_W'(8)));

  assert_seg_round_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !incompressible) |->
      (int'(bitLen) <= int'(segCount) * 64) && (int'(bitLen) > int'(segCount) * 64 - 64));

  assert_incomp_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && incompressible) |-> (segCount == SEG_W'(8)) && (int'(bitLen) > 512));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(bitLen) && $stable(segCount) && $stable(incompressible)));
endmodule

bind fpc_line_compressor fpc_checker #(.LEN_W(LEN_W), .SEG_W(SEG_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .start          (start),
  .busy           (busy),
  .done           (done),
  .bitLen         (bitLen),
  .segCount       (segCount),
  .incompressible (incompressible)
);

// File: tb/sim_fpc_line_compressor.sv
module sim_fpc_line_compressor;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int LW = NW * 32;
  localparam int MB = NW * 35;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] lineIn = '0;
  logic          busy, done, incompressible;
  logic [MB-1:0] bitStream;
  logic [9:0]    bitLen;
  logic [3:0]    segCount;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  fpc_line_compressor u0 (
    .clk(clk), .rstN(rstN), .start(start), .lineIn(lineIn),
    .busy(busy), .done(done), .bitStream(bitStream), .bitLen(bitLen),
    .segCount(segCount), .incompressible(incompressible)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [MB-1:0] act, input logic [MB-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent reference built from the requirement text
  task automatic model(input logic [LW-1:0] ln, output logic [MB-1:0] st, output int len);
    int run;
    st = '0; len = 0; run = 0;
    for (int i = 0; i < NW; i++) begin
      logic [31:0] w;
      logic [34:0] e;
      int ew;
      w = ln[32*i +: 32];
      if (w == 0) begin
        run++;
        if (run == 8 || i == NW-1) begin
          e = 35'({3'(run-1), 3'b000});
          st = st | (MB'(e) << len); len += 6; run = 0;
        end
      end else begin
        if (run > 0) begin
          e = 35'({3'(run-1), 3'b000});
          st = st | (MB'(e) << len); len += 6; run = 0;
        end
        if ($signed(w) >= -8 && $signed(w) <= 7) begin
          e = 35'({w[3:0], 3'b001}); ew = 7;
        end else if ($signed(w) >= -128 && $signed(w) <= 127) begin
          e = 35'({w[7:0], 3'b010}); ew = 11;
        end else if (w == {4{w[7:0]}}) begin
          e = 35'({w[7:0], 3'b110}); ew = 11;
        end else if ($signed(w) >= -32768 && $signed(w) <= 32767) begin
          e = 35'({w[15:0], 3'b011}); ew = 19;
        end else if (w[15:0] == 0) begin
          e = 35'({w[31:16], 3'b100}); ew = 19;
        end else if ($signed(w[31:16]) >= -128 && $signed(w[31:16]) <= 127 &&
                     $signed(w[15:0]) >= -128 && $signed(w[15:0]) <= 127) begin
          e = 35'({w[23:16], w[7:0], 3'b101}); ew = 19;
        end else begin
          e = {w, 3'b111}; ew = 35;
        end
        st = st | (MB'(e) << len); len += ew;
      end
    end
  endtask

  // Runs one line, checks done timing (R2) and the full result against the model
  task automatic runLine(input string tag, input logic [LW-1:0] ln, input bit midStart);
    logic [MB-1:0] st;
    int len, seg;
    bit inc;
    model(ln, st, len);
    seg = (len + 63) / 64;
    inc = (seg > 8);
    if (inc) seg = 8;
    @(negedge clk); lineIn = ln; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check({tag, " R2 busy"}, MB'(busy), MB'(1));
    for (int k = 0; k < 15; k++) begin
      @(posedge clk);
      if (midStart && k == 4) begin
        @(negedge clk); start = 1'b1; lineIn = ~ln;
        @(posedge clk); k++;
        @(negedge clk); start = 1'b0;
      end
    end
    @(negedge clk);
    check({tag, " R2 done early"}, MB'(done), MB'(0));
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 done"}, MB'(done), MB'(1));
    check({tag, " R7 stream"}, bitStream, st);
    check({tag, " R7 length"}, MB'(bitLen), MB'(len));
    check({tag, " R8 segments"}, MB'(segCount), MB'(seg));
    check({tag, " R8 flag"}, MB'(incompressible), MB'(inc));
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 done falls"}, MB'(done), MB'(0));
  endtask

  task automatic testReset();
    check("R1 busy", MB'(busy), MB'(0));
    check("R1 done", MB'(done), MB'(0));
    check("R1 bitLen", MB'(bitLen), MB'(0));
    check("R1 segCount", MB'(segCount), MB'(0));
    check("R1 flag", MB'(incompressible), MB'(0));
    check("R1 stream", bitStream, '0);
  endtask

  task automatic testAllZero();
    runLine("allzero R6", '0, 0);
    check("R6 two runs of eight", MB'(bitStream[11:0]), MB'(12'b111_000_111_000));
    check("R6 length", MB'(bitLen), MB'(12));
  endtask

  task automatic testAllRaw();
    logic [LW-1:0] ln;
    for (int i = 0; i < NW; i++) ln[32*i +: 32] = 32'h1234_5678 + 32'(i) * 32'h0101_0000;
    runLine("allraw", ln, 0);
    check("R3 raw entry", MB'(bitStream[34:0]), MB'({32'h1234_5678, 3'b111}));
    check("R8 incompressible", MB'(incompressible), MB'(1));
    check("R8 capped", MB'(segCount), MB'(8));
  endtask

  task automatic testPatterns();
    logic [LW-1:0] ln;
    for (int i = 0; i < NW; i++) ln[32*i +: 32] = 32'hFFFF_FFF9;
    ln[31:0]    = 32'h0000_0005;
    ln[63:32]   = 32'hFFFF_FF80;
    ln[95:64]   = 32'h0000_7FFF;
    ln[127:96]  = 32'hABCD_0000;
    ln[159:128] = 32'h007F_FF80;
    ln[191:160] = 32'h5A5A_5A5A;
    ln[223:192] = 32'h89AB_CDEF;
    runLine("patterns", ln, 0);
    check("R4 se4",   MB'(bitStream[6:0]),   MB'({4'h5, 3'b001}));
    check("R4 se8",   MB'(bitStream[17:7]),  MB'({8'h80, 3'b010}));
    check("R4 se16",  MB'(bitStream[36:18]), MB'({16'h7FFF, 3'b011}));
    check("R4 hpad",  MB'(bitStream[55:37]), MB'({16'hABCD, 3'b100}));
    check("R4 hpair", MB'(bitStream[74:56]), MB'({8'h7F, 8'h80, 3'b101}));
    check("R4 rbyte", MB'(bitStream[85:75]), MB'({8'h5A, 3'b110}));
    check("R7 length 184", MB'(bitLen), MB'(184));
    check("R8 three segments", MB'(segCount), MB'(3));
  endtask

  task automatic testTies();
    logic [LW-1:0] ln;
    for (int i = 0; i < NW; i++) ln[32*i +: 32] = 32'h0001_0001;
    ln[31:0]  = 32'hFFFF_0000;
    ln[63:32] = 32'hFFFF_FFFF;
    runLine("ties", ln, 0);
    check("R5 pad over pair", MB'(bitStream[2:0]), MB'(3'b100));
    check("R5 se4 over rbyte", MB'(bitStream[25:19]), MB'({4'hF, 3'b001}));
    check("R5 pair entry", MB'(bitStream[44:26]), MB'({8'h01, 8'h01, 3'b101}));
  endtask

  task automatic testLongRun();
    logic [LW-1:0] ln;
    ln = '0;
    ln[32*9 +: 32] = 32'h0000_0003;
    runLine("longrun", ln, 0);
    check("R6 run split at eight", MB'(bitStream[5:0]), MB'(6'b111_000));
    check("R6 run of one", MB'(bitStream[11:6]), MB'(6'b000_000));
    check("R6 tail run of six", MB'(bitStream[24:19]), MB'(6'b101_000));
    check("R6 length", MB'(bitLen), MB'(25));
  endtask

  task automatic testBoundary();
    logic [LW-1:0] ln;
    for (int i = 0; i < 14; i++) ln[32*i +: 32] = 32'h8765_4321 ^ 32'(i);
    ln[32*14 +: 32] = 32'h0000_007F;
    ln[32*15 +: 32] = 32'hFFFF_FF90;
    runLine("len512", ln, 0);
    check("R8 512 fits", MB'({segCount, incompressible}), MB'({4'd8, 1'b0}));
    ln[32*15 +: 32] = 32'h0000_1234;
    runLine("len520", ln, 0);
    check("R8 520 overflows", MB'({segCount, incompressible}), MB'({4'd8, 1'b1}));
  endtask

  task automatic testBusyStart();
    logic [LW-1:0] ln;
    for (int i = 0; i < NW; i++) ln[32*i +: 32] = (i % 3 == 0) ? 32'h0 : 32'h0000_0042;
    runLine("R9 start while busy", ln, 1);
  endtask

  task automatic testHold();
    logic [MB-1:0] s;
    logic [9:0] l;
    logic [3:0] g;
    s = bitStream; l = bitLen; g = segCount;
    lineIn = '1;
    repeat (10) @(negedge clk);
    check("R10 stream held", bitStream, s);
    check("R10 length held", MB'(bitLen), MB'(l));
    check("R10 segments held", MB'(segCount), MB'(g));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    testReset();
    @(negedge clk); rstN = 1'b1;
    testAllZero();
    testAllRaw();
    testPatterns();
    testHold();
    testTies();
    testLongRun();
    testBoundary();
    testBusyStart();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule